// File: doc/BRIEF.md
# Two-Bank Memory Mapper with Video Contention

This block sits between a processor and two DRAM banks, called A and B. It turns a flat processor physical address into a bank select and a byte offset within that bank. Bank B, which the on-board video never touches, is placed at address zero. Bank A, which holds the video frame buffer, follows directly after the last byte of bank B. As a result, processor traffic stays clear of video contention until bank B is full. Either bank may be empty. An address past the populated total raises an out-of-range flag and selects no bank.

The processor and a periodic video fetch engine both need bank A, so the block arbitrates it with a small state machine. There are three states. `ST_FREE` means nobody holds bank A. `ST_VIDEO` means a video fetch burst owns it. `ST_CPU_A` means the processor owns it for one access cycle.

The transitions are:
- free-to-video, cpu-to-video and video-hold: taken whenever video requests.
- free-to-cpu and cpu-to-cpu: taken when video is idle and the processor addresses bank A.
- video-to-cpu handoff: the burst ends while the processor is waiting for bank A.
- video-to-free and cpu-to-free: taken when nobody wants bank A.

Video has fixed priority. The processor always gets bank A in the cycle right after a burst ends. Accesses to bank B are granted combinationally and are never stalled.

Top module: `bank_mapper_top`

## Requirements
- R1: Size codes are 3 bits: 0 = empty, 1 = 1 MiB, 2 = 4 MiB, 3 = 16 MiB, 4 = 64 MiB (MiB = 2^20 bytes).
- R2: Size codes 5, 6 and 7 are illegal. Each is treated as an empty bank, and `cfg_err` is high while either bank carries one.
- R3: An address below the size of bank B gives `sel_b`=1, `sel_a`=0, and an offset equal to the address.
- R4: An address at or above the size of bank B and below size B + size A gives `sel_a`=1 and an offset of address minus size B. When bank B is empty, bank A starts at 0.
- R5: An address at or above size A + size B gives `out_of_range`=1, `sel_a`=`sel_b`=0 and offset 0.
- R6: A processor request to bank B gets `cpu_gnt` in the same cycle, whatever video is doing.
- R7: `vid_gnt` rises in the cycle after a clock edge at which `vid_req` is high. It stays high while `vid_req` is sampled high, and falls in the cycle after `vid_req` is sampled low.
- R8: A processor request to bank A is granted only in the cycle after an edge at which the request to bank A was present and video was not requesting. An out-of-range request is never granted.
- R9: When a video burst ends (an edge with `vid_gnt`=1 and `vid_req`=0) while the processor requests bank A, the processor is granted bank A in the next cycle.
- R10: `vid_gnt` and a processor grant to bank A are never high in the same cycle.
- R11: During and right after reset, the arbiter is in `ST_FREE`: `vid_gnt`=0 and no processor grant to bank A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| size_a_code | input | 3 | Size code of bank A (video bank) |
| size_b_code | input | 3 | Size code of bank B |
| cpu_addr | input | 27 | Processor physical byte address |
| cpu_req | input | 1 | Processor access request |
| vid_req | input | 1 | Video fetch request for bank A |
| sel_a | output | 1 | Address falls in bank A |
| sel_b | output | 1 | Address falls in bank B |
| bank_offset | output | 26 | Byte offset within the selected bank |
| out_of_range | output | 1 | Address beyond the populated total |
| cfg_err | output | 1 | A bank carries an illegal size code |
| cpu_gnt | output | 1 | Processor access may proceed this cycle |
| vid_gnt | output | 1 | Video owns bank A this cycle |

## Verification
Two functions can meet in one cycle. The first is the moment a video burst releases bank A. The second is a processor request that is already waiting on bank A. When they coincide, the handoff must give the processor bank A at once, while a new video request in the same cycle must still win. The bench provokes this by holding the processor on a bank-A address through a burst, then dropping `vid_req`. It also raises `vid_req` again in the processor's slot cycle, and moves the processor to a bank-B address mid-burst. A behavioural model tracks the owner of bank A each cycle and judges `cpu_gnt`, `vid_gnt` and the mapping outputs on every clock.

// File: rtl/bm_pkg.sv
package bm_pkg;
    localparam int CODE_W = 3;

    typedef enum logic [1:0] {
        ST_FREE,
        ST_VIDEO,
        ST_CPU_A
    } own_e;
endpackage

// File: rtl/bm_size_decode.sv
module bm_size_decode
    import bm_pkg::*;
#(
    parameter int ADDR_W   = 27,
    parameter int MB_SHIFT = 20
) (
    input  logic [CODE_W-1:0] code,
    output logic [ADDR_W-1:0] size,
    output logic              illegal
);
    always_comb begin
        size    = '0;
        illegal = 1'b0;
        unique case (code)
            3'd0: size = '0;
            3'd1: size[MB_SHIFT]     = 1'b1;
            3'd2: size[MB_SHIFT + 2] = 1'b1;
            3'd3: size[MB_SHIFT + 4] = 1'b1;
            3'd4: size[MB_SHIFT + 6] = 1'b1;
            default: illegal = 1'b1;
        endcase
    end
endmodule

// File: rtl/bm_addr_map.sv
module bm_addr_map #(
    parameter int ADDR_W = 27,
    parameter int OFF_W  = 26
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] size_a,
    input  logic [ADDR_W-1:0] size_b,
    output logic              sel_a,
    output logic              sel_b,
    output logic              oor,
    output logic [OFF_W-1:0]  offset
);
    localparam int SUM_W = ADDR_W + 1;

    logic [SUM_W-1:0] addr_x;
    logic [SUM_W-1:0] end_b;
    logic [SUM_W-1:0] end_a;
    logic [SUM_W-1:0] rel_a;

    always_comb begin
        addr_x = {1'b0, addr};
        end_b  = {1'b0, size_b};
        end_a  = end_b + {1'b0, size_a};
        rel_a  = addr_x - end_b;
        sel_b  = 1'b0;
        sel_a  = 1'b0;
        oor    = 1'b0;
        offset = '0;
        if (addr_x < end_b) begin
            sel_b  = 1'b1;
            offset = addr[OFF_W-1:0];
        end else if (addr_x < end_a) begin
            sel_a  = 1'b1;
            offset = rel_a[OFF_W-1:0];
        end else begin
            oor = 1'b1;
        end
    end
endmodule

// File: rtl/bm_arbiter.sv
module bm_arbiter
    import bm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic vid_req,
    input  logic cpu_want_a,
    output logic vid_gnt,
    output logic cpu_a_slot
);
    own_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FREE:  if (vid_req) state_d = ST_VIDEO;
                      else if (cpu_want_a) state_d = ST_CPU_A;
            ST_VIDEO: if (vid_req) state_d = ST_VIDEO;
                      else if (cpu_want_a) state_d = ST_CPU_A;
                      else state_d = ST_FREE;
            ST_CPU_A: if (vid_req) state_d = ST_VIDEO;
                      else if (cpu_want_a) state_d = ST_CPU_A;
                      else state_d = ST_FREE;
            default:  state_d = ST_FREE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FREE;
        else        state_q <= state_d;
    end

    always_comb begin
        vid_gnt    = 1'b0;
        cpu_a_slot = 1'b0;
        unique case (state_q)
            ST_FREE:  ;
            ST_VIDEO: vid_gnt = 1'b1;
            ST_CPU_A: cpu_a_slot = 1'b1;
            default:  ;
        endcase
    end

    // R7: video wins bank A in the cycle after it asks
    p_video_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        vid_req |=> vid_gnt);

    // R7: grant released once the request is sampled low
    p_video_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (vid_gnt && !vid_req) |=> !vid_gnt);

    // R9: waiting processor takes bank A right after a burst
    p_burst_handoff_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (vid_gnt && !vid_req && cpu_want_a) |=> cpu_a_slot);
endmodule

// File: rtl/bank_mapper_top.sv
module bank_mapper_top
    import bm_pkg::*;
#(
    parameter int MB_SHIFT = 20,
    parameter int ADDR_W   = MB_SHIFT + 7,
    parameter int OFF_W    = MB_SHIFT + 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] size_a_code,
    input  logic [CODE_W-1:0] size_b_code,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_req,
    input  logic              vid_req,
    output logic              sel_a,
    output logic              sel_b,
    output logic [OFF_W-1:0]  bank_offset,
    output logic              out_of_range,
    output logic              cfg_err,
    output logic              cpu_gnt,
    output logic              vid_gnt
);
    localparam int NBANK = 2;

    logic [NBANK-1:0][CODE_W-1:0] codes;
    logic [NBANK-1:0][ADDR_W-1:0] sizes;
    logic [NBANK-1:0]             bad;
    logic                         cpu_a_slot;
    logic                         cpu_want_a;

    assign codes = {size_b_code, size_a_code};

    for (genvar gi = 0; gi < NBANK; gi++) begin : g_dec
        bm_size_decode #(.ADDR_W(ADDR_W), .MB_SHIFT(MB_SHIFT)) u_dec (
            .code    (codes[gi]),
            .size    (sizes[gi]),
            .illegal (bad[gi])
        );
    end

    assign cfg_err = |bad;

    bm_addr_map #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_map (
        .addr   (cpu_addr),
        .size_a (sizes[0]),
        .size_b (sizes[1]),
        .sel_a  (sel_a),
        .sel_b  (sel_b),
        .oor    (out_of_range),
        .offset (bank_offset)
    );

    assign cpu_want_a = cpu_req & sel_a;

    bm_arbiter u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .vid_req    (vid_req),
        .cpu_want_a (cpu_want_a),
        .vid_gnt    (vid_gnt),
        .cpu_a_slot (cpu_a_slot)
    );

    assign cpu_gnt = cpu_req & (sel_b | (sel_a & cpu_a_slot));

    // R6: bank B traffic is never held off
    p_b_no_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && sel_b) |-> cpu_gnt);

    // R10: one owner of bank A per cycle
    p_a_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(vid_gnt && cpu_gnt && sel_a));

    // R5: out-of-range selects nothing and is never granted
    p_oor_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_of_range |-> (!sel_a && !sel_b && !cpu_gnt));
endmodule

// File: tb/bank_mapper_top_tb_top.sv
module bank_mapper_top_tb_top;
    localparam int AW = 27;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    a_code = 3'd0;
    logic [2:0]    b_code = 3'd0;
    logic [AW-1:0] addr = '0;
    logic          creq = 1'b0;
    logic          vreq = 1'b0;
    logic          sel_a, sel_b, oor, cfg_err, cpu_gnt, vid_gnt;
    logic [AW-2:0] offs;

    int checks = 0;
    int fails  = 0;
    int owner  = 0;   // 0 free, 1 video, 2 processor
    bit done   = 0;

    always #5 clk = ~clk;

    bank_mapper_top dut_i (
        .clk(clk), .rst_n(rst_n), .size_a_code(a_code), .size_b_code(b_code),
        .cpu_addr(addr), .cpu_req(creq), .vid_req(vreq), .sel_a(sel_a),
        .sel_b(sel_b), .bank_offset(offs), .out_of_range(oor),
        .cfg_err(cfg_err), .cpu_gnt(cpu_gnt), .vid_gnt(vid_gnt)
    );

    function automatic longint msize(input logic [2:0] c);
        case (c)
            3'd1: return 64'd1 << 20;
            3'd2: return 64'd1 << 22;
            3'd3: return 64'd1 << 24;
            3'd4: return 64'd1 << 26;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // compare all outputs against the model at the negedge, then advance the model
    task automatic compare_and_step();
        longint sb, sa, ad;
        bit rb, ra, ro, wa, e_cpu, e_vid;
        string rt;
        @(negedge clk);
        sb = msize(b_code); sa = msize(a_code); ad = longint'(addr);
        rb = ad < sb; ra = !rb && ad < sb + sa; ro = !rb && !ra;
        rt = rb ? "R1 R3" : (ra ? "R1 R4" : "R1 R5");
        chk(sel_b == rb, {rt, " sel_b"}, sel_b, rb);
        chk(sel_a == ra, {rt, " sel_a"}, sel_a, ra);
        chk(oor == ro, {rt, " out_of_range"}, oor, ro);
        chk(longint'(offs) == (rb ? ad : (ra ? ad - sb : 0)), {rt, " offset"},
            offs, rb ? ad : (ra ? ad - sb : 0));
        chk(cfg_err == (a_code > 4 || b_code > 4), "R2 cfg_err", cfg_err,
            a_code > 4 || b_code > 4);
        e_vid = owner == 1;
        e_cpu = creq && (rb || (ra && owner == 2));
        chk(vid_gnt == e_vid, "R7 vid_gnt", vid_gnt, e_vid);
        chk(cpu_gnt == e_cpu, rb ? "R6 cpu_gnt" : "R8 cpu_gnt", cpu_gnt, e_cpu);
        chk(!(vid_gnt && cpu_gnt && sel_a), "R10 exclusive", 1, 0);
        wa = creq && ra;
        if (vreq) owner = 1;
        else if (wa) owner = 2;
        else owner = 0;
        @(posedge clk);
        #1;
    endtask

    task automatic drive(input logic [2:0] ac, input logic [2:0] bc,
                         input longint ad, input bit cr, input bit vr);
        a_code = ac; b_code = bc; addr = AW'(ad); creq = cr; vreq = vr;
        compare_and_step();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        longint sa, sb, tot;
        // R11: reset state with video asking and processor on bank A
        a_code = 3'd1; b_code = 3'd0; addr = '0; creq = 1'b1; vreq = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(vid_gnt == 0, "R11 vid_gnt in reset", vid_gnt, 0);
        chk(cpu_gnt == 0, "R11 cpu_gnt in reset", cpu_gnt, 0);
        creq = 1'b0; vreq = 1'b0;
        @(posedge clk); #1;
        rst_n = 1'b1;
        owner = 0;
        @(negedge clk);
        chk(vid_gnt == 0, "R11 vid_gnt after reset", vid_gnt, 0);
        @(posedge clk); #1;

        // R1 R3 R4 R5: boundary sweep over every legal code pair
        for (int ac = 0; ac < 5; ac++) begin
            for (int bc = 0; bc < 5; bc++) begin
                sa = msize(3'(ac)); sb = msize(3'(bc)); tot = sa + sb;
                drive(3'(ac), 3'(bc), 0, 1, 0);
                if (sb > 0) begin
                    drive(3'(ac), 3'(bc), sb - 1, 1, 0);
                end
                drive(3'(ac), 3'(bc), sb, 1, 0);
                if (tot > 0) drive(3'(ac), 3'(bc), tot - 1, 1, 0);
                if (tot < (64'd1 << AW)) drive(3'(ac), 3'(bc), tot, 1, 0);
                drive(3'(ac), 3'(bc), (64'd1 << AW) - 1, 1, 0);
            end
        end

        // R2: illegal codes act as empty
        for (int ic = 5; ic < 8; ic++) begin
            drive(3'(ic), 3'd2, 64'd1 << 22, 1, 0);
            drive(3'd1, 3'(ic), 0, 1, 0);
            drive(3'd1, 3'(ic), 64'd1 << 20, 1, 0);
        end

        // R6 R7 R8 R9: burst with processor waiting on bank A (A = 1 MiB after B = 4 MiB)
        drive(3'd1, 3'd2, (64'd1 << 22) + 16, 1, 1);
        for (int k = 0; k < 4; k++) drive(3'd1, 3'd2, (64'd1 << 22) + 16, 1, 1);
        drive(3'd1, 3'd2, 64, 1, 1);                    // R6: bank B mid-burst
        drive(3'd1, 3'd2, (64'd1 << 22) + 32, 1, 0);    // burst ends, A waiting
        @(negedge clk);
        chk(cpu_gnt == 1, "R9 handoff grant", cpu_gnt, 1);
        @(posedge clk); #1;
        owner = 2;
        drive(3'd1, 3'd2, (64'd1 << 22) + 32, 1, 1);    // video returns in slot cycle
        drive(3'd1, 3'd2, (64'd1 << 22) + 32, 1, 0);
        drive(3'd1, 3'd2, (64'd1 << 22) + 32, 0, 0);
        drive(3'd1, 3'd2, (64'd1 << 22) + 32, 1, 0);    // R8: one-cycle wait when free
        drive(3'd1, 3'd2, (64'd1 << 22) + 32, 1, 0);
        drive(3'd1, 3'd2, 1 << 27 - 1, 1, 0);

        // mixed traffic
        for (int n = 0; n < 4000; n++) begin
            logic [2:0] ac, bc;
            longint ad;
            ac = 3'($urandom % 6);
            bc = 3'($urandom % 6);
            tot = msize(ac) + msize(bc);
            ad = longint'($urandom) % (tot + 4096);
            if (ad >= (64'd1 << AW)) ad = (64'd1 << AW) - 1;
            drive(ac, bc, ad, ($urandom % 4) != 0, ($urandom % 3) == 0);
            if (n % 200 == 0) begin
                for (int m = 0; m < 5; m++) drive(3'd2, 3'd1, (64'd1 << 20) + m, 1, m < 3);
            end
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule